// File: doc/BRIEF.md
# Spatial Region Generation Tracker

The block sits next to a primary data cache and watches every access. The address space is split into fixed-size regions of several cache blocks. During one region "generation" the block records which blocks of that region are touched. A generation starts with a trigger access. It ends when any block of the region leaves the cache, either by eviction or by invalidation. When a generation that touched at least two distinct blocks ends, the block emits a training record. The record carries the PC and the block offset of the trigger access, together with a bit vector of the blocks that were touched. A downstream pattern store learns from these records.

Two associative tables do the tracking. The first is a small filter table. It holds generations that have so far touched only one block. The second is an accumulation table. It holds generations that have touched two or more distinct blocks, each with its bit vector. Single-block generations never reach the accumulation table, so they take no space there and they produce no record. When a table is full, a round-robin pointer picks the entry to replace. A replaced filter entry is dropped. A replaced accumulation entry is emitted as a record.

Top module: `spatial_gen_tracker`

## Requirements
- R1: After reset both tables are empty and `trainValid` is 0. An eviction given before any access produces no record.
- R2: The region tag is the address bits above log2(REGION_BYTES). The block offset is the address bits [log2(REGION_BYTES)-1 : log2(BLOCK_BYTES)]. The byte bits below the block have no effect. In a record, `trainOffset` is a block index, and bit i of `trainPattern` stands for block i of the region.
- R3: An access whose region is in neither table is a trigger and is placed in the filter table. A generation that ends while it is still in the filter table is discarded and produces no record.
- R4: An access that hits the filter table with the same block offset as the stored trigger changes nothing. The stored PC and offset are kept.
- R5: An access that hits the filter table with a different block offset moves the generation to the accumulation table. Its pattern then holds both the trigger bit and the new bit. The trigger PC and offset are kept. A region is tracked by at most one entry across both tables.
- R6: An access that hits the accumulation table sets the pattern bit of its block offset.
- R7: An eviction of any block of a region held in the accumulation table emits that generation's record and frees the entry. A second eviction of the same region then produces nothing.
- R8: A trigger that finds the filter table full replaces the entry under a round-robin pointer, starting at entry 0. The replaced generation is dropped. Free entries are filled lowest index first.
- R9: A promotion that finds the accumulation table full replaces the entry under a round-robin pointer, starting at entry 0. The replaced generation is emitted as a record.
- R10: When an access and an eviction in the same cycle refer to the same region, the eviction is applied first. The access then starts a new generation as a trigger.
- R11: A record appears as `trainValid` high for exactly one cycle, in the cycle after the input that ended the generation. If an eviction record and a replacement record would occur in the same cycle, the eviction record is the one sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| accessValid | input | 1 | A cache data access is presented this cycle |
| accessAddr | input | ADDR_W | Byte address of the access |
| accessPc | input | PC_W | PC of the instruction making the access |
| evictValid | input | 1 | A block eviction or invalidation is presented this cycle |
| evictAddr | input | ADDR_W | Address of the block that leaves the cache |
| trainValid | output | 1 | One-cycle pulse marking a training record |
| trainPc | output | PC_W | Trigger PC of the ended generation |
| trainOffset | output | log2(REGION_BYTES/BLOCK_BYTES) | Trigger block offset of the ended generation |
| trainPattern | output | REGION_BYTES/BLOCK_BYTES | Blocks touched during the generation |

## Verification
The bench builds the block with 16-bit addresses and PCs, 512-byte regions of 64-byte blocks, and four entries in each table. With these values each pattern is 8 bits wide. Both tables fill after four regions, so a few accesses are enough to make the round-robin pointers replace entries in both tables. Accesses, evictions and same-cycle collisions are also checked for short pattern sequences whose records can be predicted bit by bit.

// File: rtl/sgt_pkg.sv
package sgt_pkg;

  // Largest table depth the index encoder handles.
  localparam int IDX_W = 8;
  localparam int MAX_N = 1 << IDX_W;

  // Per-cycle strobes sent from the control to the tables.
  typedef struct packed {
    logic evFilt;     // drop the filter entry hit by the eviction
    logic evAcc;      // emit and free the accumulation entry hit by the eviction
    logic setBit;     // set a pattern bit in an accumulation entry
    logic filtAlloc;  // write a new trigger into the filter table
    logic promote;    // move a filter entry into the accumulation table
    logic emitVictim; // the accumulation slot being overwritten is emitted
  } sgt_ctl_t;

  // Index of the lowest set bit; zero when no bit is set.
  function automatic logic [IDX_W-1:0] lowIdx(input logic [MAX_N-1:0] v);
    lowIdx = '0;
    for (int i = MAX_N - 1; i >= 0; i--) begin
      if (v[i]) lowIdx = IDX_W'(i);
    end
  endfunction

endpackage

// File: rtl/sgt_ctrl.sv
module sgt_ctrl
  import sgt_pkg::*;
#(
  parameter int OFF_W  = 5,
  parameter int FILT_N = 32,
  parameter int ACC_N  = 64,
  localparam int FIW   = $clog2(FILT_N),
  localparam int AIW   = $clog2(ACC_N)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accessValid,
  input  logic              evValid,
  input  logic [OFF_W-1:0]  accOff,
  input  logic [OFF_W-1:0]  filtHitOff,
  input  logic [FILT_N-1:0] filtValid,
  input  logic [ACC_N-1:0]  accValid,
  input  logic [FILT_N-1:0] filtHitA,
  input  logic [ACC_N-1:0]  accHitA,
  input  logic [FILT_N-1:0] filtHitE,
  input  logic [ACC_N-1:0]  accHitE,
  output sgt_ctl_t          ctl,
  output logic [FIW-1:0]    evFiltIdx,
  output logic [AIW-1:0]    evAccIdx,
  output logic [AIW-1:0]    setIdx,
  output logic [FIW-1:0]    filtIdx,
  output logic [FIW-1:0]    promFiltIdx,
  output logic [AIW-1:0]    accIdx
);

  logic [FILT_N-1:0] killF, liveHitF, freeF;
  logic [ACC_N-1:0]  killA, liveHitA, freeA;
  logic              aHit, fHit, trig;
  logic [FIW-1:0]    filtRr;
  logic [AIW-1:0]    accRr;

  // The eviction is applied first: entries it kills are invisible to the access.
  always_comb begin
    killF    = evValid ? filtHitE : '0;
    killA    = evValid ? accHitE  : '0;
    liveHitF = filtHitA & ~killF;
    liveHitA = accHitA  & ~killA;
    freeF    = ~filtValid | killF;
    freeA    = ~accValid  | killA;
    aHit     = accessValid && (|liveHitA);
    fHit     = accessValid && !aHit && (|liveHitF);
    trig     = accessValid && !aHit && !(|liveHitF);
  end

  always_comb begin
    ctl.evFilt     = evValid && (|filtHitE);
    ctl.evAcc      = evValid && (|accHitE);
    ctl.setBit     = aHit;
    ctl.filtAlloc  = trig;
    ctl.promote    = fHit && (filtHitOff != accOff);
    ctl.emitVictim = ctl.promote && !(|freeA);
    evFiltIdx      = FIW'(lowIdx(MAX_N'(filtHitE)));
    evAccIdx       = AIW'(lowIdx(MAX_N'(accHitE)));
    setIdx         = AIW'(lowIdx(MAX_N'(liveHitA)));
    promFiltIdx    = FIW'(lowIdx(MAX_N'(liveHitF)));
    filtIdx        = (|freeF) ? FIW'(lowIdx(MAX_N'(freeF))) : filtRr;
    accIdx         = (|freeA) ? AIW'(lowIdx(MAX_N'(freeA))) : accRr;
  end

  // Round-robin replacement pointers advance only when they are used.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      filtRr <= '0;
      accRr  <= '0;
    end else begin
      if (trig && !(|freeF))
        filtRr <= (filtRr == FIW'(FILT_N - 1)) ? '0 : filtRr + 1'b1;
      if (ctl.emitVictim)
        accRr <= (accRr == AIW'(ACC_N - 1)) ? '0 : accRr + 1'b1;
    end
  end

  // R11: a record source exists only when the eviction frees nothing in the accumulation table.
  assert_no_double_emit_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.evAcc && ctl.emitVictim));

endmodule

// File: rtl/sgt_tables.sv
module sgt_tables
  import sgt_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int TAG_W  = 21,
  parameter int OFF_W  = 5,
  parameter int FILT_N = 32,
  parameter int ACC_N  = 64,
  localparam int PAT_W = 1 << OFF_W,
  localparam int FIW   = $clog2(FILT_N),
  localparam int AIW   = $clog2(ACC_N)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TAG_W-1:0]  accTag,
  input  logic [OFF_W-1:0]  accOff,
  input  logic [PC_W-1:0]   accPc,
  input  logic [TAG_W-1:0]  evTag,
  input  sgt_ctl_t          ctl,
  input  logic [FIW-1:0]    evFiltIdx,
  input  logic [AIW-1:0]    evAccIdx,
  input  logic [AIW-1:0]    setIdx,
  input  logic [FIW-1:0]    filtIdx,
  input  logic [FIW-1:0]    promFiltIdx,
  input  logic [AIW-1:0]    accIdx,
  output logic [FILT_N-1:0] filtValid,
  output logic [ACC_N-1:0]  accValid,
  output logic [FILT_N-1:0] filtHitA,
  output logic [ACC_N-1:0]  accHitA,
  output logic [FILT_N-1:0] filtHitE,
  output logic [ACC_N-1:0]  accHitE,
  output logic [OFF_W-1:0]  filtHitOff,
  output logic              trainValid,
  output logic [PC_W-1:0]   trainPc,
  output logic [OFF_W-1:0]  trainOff,
  output logic [PAT_W-1:0]  trainPat
);

  logic [TAG_W-1:0] fTag [FILT_N];
  logic [PC_W-1:0]  fPc  [FILT_N];
  logic [OFF_W-1:0] fOff [FILT_N];
  logic [TAG_W-1:0] aTag [ACC_N];
  logic [PC_W-1:0]  aPc  [ACC_N];
  logic [OFF_W-1:0] aOff [ACC_N];
  logic [PAT_W-1:0] aPat [ACC_N];
  logic [AIW-1:0]   trainSel;

  // Associative search of both tables for the access and the eviction.
  for (genvar i = 0; i < FILT_N; i++) begin : gFiltCam
    assign filtHitA[i] = filtValid[i] && (fTag[i] == accTag);
    assign filtHitE[i] = filtValid[i] && (fTag[i] == evTag);
  end
  for (genvar j = 0; j < ACC_N; j++) begin : gAccCam
    assign accHitA[j] = accValid[j] && (aTag[j] == accTag);
    assign accHitE[j] = accValid[j] && (aTag[j] == evTag);
  end

  always_comb begin
    filtHitOff = '0;
    for (int i = 0; i < FILT_N; i++)
      if (filtHitA[i]) filtHitOff = filtHitOff | fOff[i];
  end

  assign trainSel = ctl.evAcc ? evAccIdx : accIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      filtValid  <= '0;
      accValid   <= '0;
      trainValid <= 1'b0;
      trainPc    <= '0;
      trainOff   <= '0;
      trainPat   <= '0;
    end else begin
      if (ctl.evFilt)    filtValid[evFiltIdx]   <= 1'b0;
      if (ctl.promote)   filtValid[promFiltIdx] <= 1'b0;
      if (ctl.filtAlloc) filtValid[filtIdx]     <= 1'b1;
      if (ctl.evAcc)     accValid[evAccIdx]     <= 1'b0;
      if (ctl.promote)   accValid[accIdx]       <= 1'b1;
      trainValid <= ctl.evAcc || ctl.emitVictim;
      if (ctl.evAcc || ctl.emitVictim) begin
        trainPc  <= aPc[trainSel];
        trainOff <= aOff[trainSel];
        trainPat <= aPat[trainSel];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.filtAlloc) begin
      fTag[filtIdx] <= accTag;
      fPc[filtIdx]  <= accPc;
      fOff[filtIdx] <= accOff;
    end
    if (ctl.setBit) aPat[setIdx][accOff] <= 1'b1;
    if (ctl.promote) begin
      aTag[accIdx] <= fTag[promFiltIdx];
      aPc[accIdx]  <= fPc[promFiltIdx];
      aOff[accIdx] <= fOff[promFiltIdx];
      aPat[accIdx] <= (PAT_W'(1) << fOff[promFiltIdx]) | (PAT_W'(1) << accOff);
    end
  end

  // R5: a region lives in at most one entry across both tables.
  assert_one_owner_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(filtHitA) && $onehot0(accHitA) && !((|filtHitA) && (|accHitA)));

  // R5: each table gains at most one entry per cycle.
  assert_alloc_growth_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(filtValid) <= $past($countones(filtValid)) + 1) &&
    ($countones(accValid)  <= $past($countones(accValid)) + 1));

endmodule

// File: rtl/spatial_gen_tracker.sv
module spatial_gen_tracker
  import sgt_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int PC_W         = 32,
  parameter int BLOCK_BYTES  = 64,
  parameter int REGION_BYTES = 2048,
  parameter int FILT_N       = 32,
  parameter int ACC_N        = 64,
  localparam int BLK_W = $clog2(BLOCK_BYTES),
  localparam int REG_W = $clog2(REGION_BYTES),
  localparam int OFF_W = REG_W - BLK_W,
  localparam int PAT_W = REGION_BYTES / BLOCK_BYTES,
  localparam int TAG_W = ADDR_W - REG_W,
  localparam int FIW   = $clog2(FILT_N),
  localparam int AIW   = $clog2(ACC_N)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accessValid,
  input  logic [ADDR_W-1:0] accessAddr,
  input  logic [PC_W-1:0]   accessPc,
  input  logic              evictValid,
  input  logic [ADDR_W-1:0] evictAddr,
  output logic              trainValid,
  output logic [PC_W-1:0]   trainPc,
  output logic [OFF_W-1:0]  trainOffset,
  output logic [PAT_W-1:0]  trainPattern
);

  sgt_ctl_t          ctl;
  logic [FILT_N-1:0] filtValid, filtHitA, filtHitE;
  logic [ACC_N-1:0]  accValid, accHitA, accHitE;
  logic [OFF_W-1:0]  filtHitOff;
  logic [FIW-1:0]    evFiltIdx, filtIdx, promFiltIdx;
  logic [AIW-1:0]    evAccIdx, setIdx, accIdx;
  logic [TAG_W-1:0]  accTag, evTag;
  logic [OFF_W-1:0]  accOff;
  logic              unusedLowBits;

  assign accTag        = accessAddr[ADDR_W-1:REG_W];
  assign accOff        = accessAddr[REG_W-1:BLK_W];
  assign evTag         = evictAddr[ADDR_W-1:REG_W];
  assign unusedLowBits = ^{accessAddr[BLK_W-1:0], evictAddr[REG_W-1:0]};

  sgt_ctrl #(.OFF_W(OFF_W), .FILT_N(FILT_N), .ACC_N(ACC_N)) uCtrl (
    .clk, .rstN, .accessValid, .evValid(evictValid), .accOff, .filtHitOff,
    .filtValid, .accValid, .filtHitA, .accHitA, .filtHitE, .accHitE,
    .ctl, .evFiltIdx, .evAccIdx, .setIdx, .filtIdx, .promFiltIdx, .accIdx
  );

  sgt_tables #(.PC_W(PC_W), .TAG_W(TAG_W), .OFF_W(OFF_W),
               .FILT_N(FILT_N), .ACC_N(ACC_N)) uTables (
    .clk, .rstN, .accTag, .accOff, .accPc(accessPc), .evTag, .ctl,
    .evFiltIdx, .evAccIdx, .setIdx, .filtIdx, .promFiltIdx, .accIdx,
    .filtValid, .accValid, .filtHitA, .accHitA, .filtHitE, .accHitE, .filtHitOff,
    .trainValid, .trainPc, .trainOff(trainOffset), .trainPat(trainPattern)
  );

  // R7: ending a generation held in the accumulation table yields a record next cycle.
  assert_evict_emits_R7: assert property (@(posedge clk) disable iff (!rstN)
    (evictValid && (|accHitE)) |=> trainValid);

  // R3: a generation ending in the filter table, with no access alongside, yields nothing.
  assert_filter_silent_R3: assert property (@(posedge clk) disable iff (!rstN)
    (evictValid && (|filtHitE) && !accessValid) |=> !trainValid);

  // R9: a promotion into a full accumulation table emits the replaced generation.
  assert_victim_emits_R9: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.promote && (&accValid) && !(evictValid && (|accHitE))) |=> trainValid);

endmodule

// File: tb/tb_spatial_gen_tracker.sv
`timescale 1ns/1ps
module tb_spatial_gen_tracker;

  logic        clk = 1'b0;
  logic        rstN;
  logic        accessValid, evictValid;
  logic [15:0] accessAddr, accessPc, evictAddr;
  logic        trainValid;
  logic [15:0] trainPc;
  logic [2:0]  trainOffset;
  logic [7:0]  trainPattern;
  int          nChecks = 0;
  int          nFails  = 0;

  always #2.5 clk = ~clk;

  spatial_gen_tracker #(
    .ADDR_W(16), .PC_W(16), .BLOCK_BYTES(64), .REGION_BYTES(512),
    .FILT_N(4), .ACC_N(4)
  ) dut (
    .clk, .rstN, .accessValid, .accessAddr, .accessPc, .evictValid, .evictAddr,
    .trainValid, .trainPc, .trainOffset, .trainPattern
  );

  typedef struct packed {
    logic        av;
    logic [15:0] aa;
    logic [15:0] ap;
    logic        ev;
    logic [15:0] ea;
    logic        xv;
    logic [15:0] xp;
    logic [2:0]  xo;
    logic [7:0]  xt;
    logic [3:0]  rq;
  } vec_t;

  // Region A at 0x1000, region B at 0x2000; offset = addr[8:6].
  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 16'h10C0, 16'h0011, 1'b0, 16'h0000, 1'b0, 16'h0000, 3'd0, 8'h00, 4'd3},  // R3 trigger
    '{1'b0, 16'h0000, 16'h0000, 1'b1, 16'h10C0, 1'b0, 16'h0000, 3'd0, 8'h00, 4'd3},  // R3 drop
    '{1'b1, 16'h1040, 16'h0022, 1'b0, 16'h0000, 1'b0, 16'h0000, 3'd0, 8'h00, 4'd3},  // R3 trigger off1
    '{1'b1, 16'h1040, 16'h0033, 1'b0, 16'h0000, 1'b0, 16'h0000, 3'd0, 8'h00, 4'd4},  // R4 same offset
    '{1'b1, 16'h1140, 16'h0044, 1'b0, 16'h0000, 1'b0, 16'h0000, 3'd0, 8'h00, 4'd5},  // R5 promote off5
    '{1'b1, 16'h117C, 16'h0045, 1'b0, 16'h0000, 1'b0, 16'h0000, 3'd0, 8'h00, 4'd2},  // R2 byte bits
    '{1'b1, 16'h11C0, 16'h0046, 1'b0, 16'h0000, 1'b0, 16'h0000, 3'd0, 8'h00, 4'd6},  // R6 set off7
    '{1'b0, 16'h0000, 16'h0000, 1'b1, 16'h1000, 1'b1, 16'h0022, 3'd1, 8'hA2, 4'd7},  // R7 record
    '{1'b0, 16'h0000, 16'h0000, 1'b1, 16'h1000, 1'b0, 16'h0000, 3'd0, 8'h00, 4'd7},  // R7 freed
    '{1'b1, 16'h2080, 16'h0055, 1'b0, 16'h0000, 1'b0, 16'h0000, 3'd0, 8'h00, 4'd3},  // R3 B trigger
    '{1'b1, 16'h2100, 16'h0066, 1'b0, 16'h0000, 1'b0, 16'h0000, 3'd0, 8'h00, 4'd5},  // R5 B promote
    '{1'b1, 16'h2180, 16'h0077, 1'b1, 16'h2080, 1'b1, 16'h0055, 3'd2, 8'h14, 4'd10}, // R10 collision
    '{1'b1, 16'h20C0, 16'h0088, 1'b0, 16'h0000, 1'b0, 16'h0000, 3'd0, 8'h00, 4'd10}, // R10 promote new gen
    '{1'b0, 16'h0000, 16'h0000, 1'b0, 16'h0000, 1'b0, 16'h0000, 3'd0, 8'h00, 4'd11}, // R11 idle
    '{1'b0, 16'h0000, 16'h0000, 1'b1, 16'h21FF, 1'b1, 16'h0077, 3'd6, 8'h48, 4'd10}  // R10 new gen record
  };

  task automatic check(input logic xv, input logic [15:0] xp, input logic [2:0] xo,
                       input logic [7:0] xt, input int rq);
    nChecks++;
    if (trainValid !== xv || (xv && (trainPc !== xp || trainOffset !== xo ||
                                      trainPattern !== xt))) begin
      nFails++;
      $display("FAIL R%0d: got v=%0b pc=%h off=%0d pat=%h, expected v=%0b pc=%h off=%0d pat=%h",
               rq, trainValid, trainPc, trainOffset, trainPattern, xv, xp, xo, xt);
    end
  endtask

  // Drive one cycle of inputs after a falling edge, then wait for the next falling edge.
  task automatic step(input logic av, input logic [15:0] aa, input logic [15:0] ap,
                      input logic ev, input logic [15:0] ea);
    accessValid = av; accessAddr = aa; accessPc = ap;
    evictValid  = ev; evictAddr  = ea;
    @(negedge clk);
  endtask

  initial begin
    #1000000;
    nFails++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    accessValid = 1'b0; accessAddr = '0; accessPc = '0;
    evictValid  = 1'b0; evictAddr  = '0;
    repeat (3) @(negedge clk);
    check(1'b0, 16'h0, 3'd0, 8'h0, 1);                 // R1 during reset
    rstN = 1'b1;
    step(1'b0, 16'h0, 16'h0, 1'b1, 16'h5000);
    check(1'b0, 16'h0, 3'd0, 8'h0, 1);                 // R1 empty after reset

    for (int i = 0; i < NV; i++) begin
      step(VEC[i].av, VEC[i].aa, VEC[i].ap, VEC[i].ev, VEC[i].ea);
      check(VEC[i].xv, VEC[i].xp, VEC[i].xo, VEC[i].xt, int'(VEC[i].rq));
    end

    // R8: fill the filter with regions C0..C3, then C4 replaces entry 0 (C0).
    for (int k = 0; k < 5; k++) begin
      step(1'b1, 16'h3000 + 16'(k) * 16'h0200, 16'h00C0 + 16'(k), 1'b0, 16'h0);
      check(1'b0, 16'h0, 3'd0, 8'h0, 8);
    end
    step(1'b1, 16'h3080, 16'h00A2, 1'b0, 16'h0);       // C0 is a fresh trigger; C1 replaced
    check(1'b0, 16'h0, 3'd0, 8'h0, 8);
    step(1'b1, 16'h30C0, 16'h00A3, 1'b0, 16'h0);
    check(1'b0, 16'h0, 3'd0, 8'h0, 8);
    step(1'b0, 16'h0, 16'h0, 1'b1, 16'h3000);
    check(1'b1, 16'h00A2, 3'd2, 8'h0C, 8);             // R8 C0 restarted at off2
    step(1'b1, 16'h3340, 16'h00B5, 1'b0, 16'h0);       // C1 was dropped: new trigger
    step(1'b1, 16'h3380, 16'h00B6, 1'b0, 16'h0);
    step(1'b0, 16'h0, 16'h0, 1'b1, 16'h3200);
    check(1'b1, 16'h00B5, 3'd5, 8'h60, 8);             // R8 second replacement
    for (int k = 2; k < 5; k++) begin
      step(1'b0, 16'h0, 16'h0, 1'b1, 16'h3000 + 16'(k) * 16'h0200);
      check(1'b0, 16'h0, 3'd0, 8'h0, 3);               // R3 filter generations end silently
    end

    // R9: fill the accumulation table with D0..D3, then D4 replaces entry 0 (D0).
    for (int k = 0; k < 4; k++) begin
      step(1'b1, 16'h4000 + 16'(k) * 16'h0200, 16'h00D0 + 16'(k), 1'b0, 16'h0);
      step(1'b1, 16'h4040 + 16'(k) * 16'h0200, 16'h00E0, 1'b0, 16'h0);
      check(1'b0, 16'h0, 3'd0, 8'h0, 9);
    end
    step(1'b1, 16'h4800, 16'h00D4, 1'b0, 16'h0);
    check(1'b0, 16'h0, 3'd0, 8'h0, 9);
    step(1'b1, 16'h4840, 16'h00E4, 1'b0, 16'h0);
    check(1'b1, 16'h00D0, 3'd0, 8'h03, 9);             // R9 replaced generation emitted
    step(1'b0, 16'h0, 16'h0, 1'b0, 16'h0);
    check(1'b0, 16'h0, 3'd0, 8'h0, 11);                // R11 single-cycle pulse
    step(1'b0, 16'h0, 16'h0, 1'b1, 16'h4000);
    check(1'b0, 16'h0, 3'd0, 8'h0, 9);                 // R9 D0 no longer tracked
    step(1'b0, 16'h0, 16'h0, 1'b1, 16'h4200);
    check(1'b1, 16'h00D1, 3'd0, 8'h03, 7);             // R7 D1 still tracked

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule